// File: doc/BRIEF.md
# I2C Memory Write Target Front End

This block is the bus-facing half of a small serial memory. It watches the two I2C lines with the system clock and finds Start and Stop conditions. It collects bytes most significant bit first and pulls SDA low during the acknowledge clock through an open-drain enable. The first byte after a Start must select this target and request a write. The second byte is the memory location, which is announced with a one-cycle load strobe. Every byte after that is a payload byte for the page buffer downstream.

Payload bytes leave through a valid/ready stream. `data_valid` rises when a payload byte has been received and stays high, with `data_byte` unchanged, until the cycle in which `data_ready` is also high. The stream has one slot. The bus cannot be stalled, so back-pressure is shown on the bus instead: a payload byte that completes while the slot is still occupied gets no acknowledge and is discarded. A Stop that ends a transfer which delivered payload makes the block raise a one-cycle commit strobe. The strobe comes once the slot is empty, so it always follows the last payload byte. While the memory reports a self-timed write cycle, the block does not answer its address.

A parameter chooses whether the three chip-select bits of the select byte must equal the `chip_sel` pins or are ignored.

Top module: `i2c_eeprom_wr_target`

## Requirements
- R1: Coming out of reset, `sda_oe`, `data_valid`, `addr_load` and `commit` are all low.
- R2: A select byte whose bits 7..4 are 1010, whose bits 3..1 equal `chip_sel` and whose bit 0 (direction) is 0 is acknowledged: `sda_oe` is high during the ninth SCL high phase of that byte.
- R3: A select byte with a wrong device code (bits 7..4) or a wrong chip select (bits 3..1) is not acknowledged. Later bytes are then neither acknowledged nor forwarded until the next Start.
- R4: When `IGNORE_CS` is 1, bits 3..1 of the select byte are not compared, and any value is acknowledged.
- R5: The byte after an acknowledged select byte is acknowledged and appears on `addr_byte` together with a single-cycle `addr_load` pulse.
- R6: Each byte after the address byte is acknowledged and delivered on `data_byte` with `data_valid`. The byte stays unchanged until `data_ready` is seen.
- R7: A payload byte that completes while `data_valid` is high and `data_ready` is low is not acknowledged and is discarded. The waiting byte is kept.
- R8: A Stop after at least one forwarded payload byte produces exactly one single-cycle `commit` pulse, and only while `data_valid` is low.
- R9: A Stop with no payload byte since the last Start produces no `commit`.
- R10: While `mem_busy` is high, a select byte is not acknowledged and the transfer is ignored.
- R11: A repeated Start in the middle of a transfer discards the transfer without `commit`, and the next byte is treated as a select byte.
- R12: A select byte with bit 0 set to 1 (read) is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| chip_sel | input | 3 | Strapped chip-select value |
| mem_busy | input | 1 | Memory is running its internal write cycle |
| sda_oe | output | 1 | High pulls SDA low (acknowledge) |
| addr_load | output | 1 | One-cycle strobe: `addr_byte` holds the word address |
| addr_byte | output | 8 | Received word address |
| data_valid | output | 1 | Payload byte available |
| data_ready | input | 1 | Downstream takes the payload byte |
| data_byte | output | 8 | Payload byte |
| commit | output | 1 | One-cycle strobe to start the internal write |

## Verification
A wrong transfer phase shows on the bus at the very next acknowledge clock. The block then acknowledges a byte it should refuse, or leaves a byte unanswered, within nine SCL periods of the fault. A lost payload flag shows at the next Stop as a missing or extra `commit`. A bad slot state shows at once as `data_byte` changing while `data_ready` is low, or as a refused byte while the slot is free.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SEL  = 2'd1,
    PH_ADDR = 2'd2,
    PH_DATA = 2'd3
  } xfer_phase_t;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  // Idle bus is high, so the chains reset high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         scl_rise,
  input  logic         scl_fall,
  input  logic         sda_s,
  output logic         byte_done,
  output logic [W-1:0] byte_val,
  output logic         ack_begin,
  output logic         ack_end
);
  localparam int CNT_W = $clog2(W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);
  localparam logic [CNT_W-1:0] ACK_WAIT = CNT_W'(W);
  localparam logic [CNT_W-1:0] ACK_HIGH = CNT_W'(W + 1);

  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (scl_rise) begin
      if (cnt < ACK_WAIT) shreg <= {shreg[W-2:0], sda_s};
      if (cnt <= ACK_WAIT) cnt <= cnt + 1'b1;
    end else if (scl_fall && cnt == ACK_HIGH) begin
      cnt <= '0;
    end
  end

  assign byte_done = scl_rise && (cnt == LAST_BIT) && !restart;
  assign byte_val  = {shreg[W-2:0], sda_s};
  assign ack_begin = scl_fall && (cnt == ACK_WAIT);
  assign ack_end   = scl_fall && (cnt == ACK_HIGH);
endmodule

// File: rtl/i2c_wr_ctrl.sv
module i2c_wr_ctrl
  import i2c_wr_pkg::*;
#(
  parameter int         W         = 8,
  parameter int         CS_W      = 3,
  parameter logic [3:0] DEV_CODE  = 4'b1010,
  parameter bit         IGNORE_CS = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic            byte_done,
  input  logic [W-1:0]    byte_val,
  input  logic            ack_begin,
  input  logic            ack_end,
  input  logic [CS_W-1:0] chip_sel,
  input  logic            mem_busy,
  input  logic            data_ready,
  output logic            sda_oe,
  output logic            addr_load,
  output logic [W-1:0]    addr_byte,
  output logic            data_valid,
  output logic [W-1:0]    data_byte,
  output logic            commit
);
  xfer_phase_t phase;
  logic ack_want, got_data, pend_commit;
  logic cs_hit, sel_ok, slot_free;

  generate
    if (IGNORE_CS) begin : g_cs_any
      assign cs_hit = 1'b1;
    end else begin : g_cs_cmp
      assign cs_hit = (byte_val[CS_W:1] == chip_sel);
    end
  endgenerate

  assign sel_ok = (byte_val[W-1:W-4] == DEV_CODE) && cs_hit &&
                  !byte_val[0] && !mem_busy;
  assign slot_free = !data_valid || data_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      ack_want    <= 1'b0;
      got_data    <= 1'b0;
      pend_commit <= 1'b0;
      sda_oe      <= 1'b0;
      addr_load   <= 1'b0;
      addr_byte   <= '0;
      data_valid  <= 1'b0;
      data_byte   <= '0;
      commit      <= 1'b0;
    end else begin
      addr_load <= 1'b0;
      commit    <= 1'b0;
      if (data_valid && data_ready) data_valid <= 1'b0;

      if (start_det) begin
        phase    <= PH_SEL;
        ack_want <= 1'b0;
        sda_oe   <= 1'b0;
        got_data <= 1'b0;
      end else if (stop_det) begin
        phase    <= PH_IDLE;
        ack_want <= 1'b0;
        sda_oe   <= 1'b0;
        got_data <= 1'b0;
        if (got_data) pend_commit <= 1'b1;
      end else begin
        if (byte_done) begin
          unique case (phase)
            PH_SEL: begin
              ack_want <= sel_ok;
              phase    <= sel_ok ? PH_ADDR : PH_IDLE;
            end
            PH_ADDR: begin
              ack_want  <= 1'b1;
              addr_load <= 1'b1;
              addr_byte <= byte_val;
              phase     <= PH_DATA;
            end
            PH_DATA: begin
              ack_want <= slot_free;
              if (slot_free) begin
                data_valid <= 1'b1;
                data_byte  <= byte_val;
                got_data   <= 1'b1;
              end
            end
            default: ack_want <= 1'b0;
          endcase
        end
        if (ack_begin) sda_oe <= ack_want;
        if (ack_end) begin
          sda_oe   <= 1'b0;
          ack_want <= 1'b0;
        end
      end

      if (pend_commit && !data_valid) begin
        commit      <= 1'b1;
        pend_commit <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_wr_target.sv
module i2c_eeprom_wr_target #(
  parameter int         SYNC_STAGES = 2,
  parameter int         CS_W        = 3,
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter bit         IGNORE_CS   = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic [CS_W-1:0] chip_sel,
  input  logic            mem_busy,
  output logic            sda_oe,
  output logic            addr_load,
  output logic [7:0]      addr_byte,
  output logic            data_valid,
  input  logic            data_ready,
  output logic [7:0]      data_byte,
  output logic            commit
);
  localparam int W = 8;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic byte_done, ack_begin, ack_end;
  logic [W-1:0] byte_val;

  i2c_line_sampler #(.STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_bit_engine #(.W(W)) u_bits (
    .clk(clk), .rst_n(rst_n), .restart(start_det | stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .byte_done(byte_done), .byte_val(byte_val),
    .ack_begin(ack_begin), .ack_end(ack_end)
  );

  i2c_wr_ctrl #(
    .W(W), .CS_W(CS_W), .DEV_CODE(DEV_CODE), .IGNORE_CS(IGNORE_CS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .byte_done(byte_done), .byte_val(byte_val),
    .ack_begin(ack_begin), .ack_end(ack_end),
    .chip_sel(chip_sel), .mem_busy(mem_busy), .data_ready(data_ready),
    .sda_oe(sda_oe), .addr_load(addr_load), .addr_byte(addr_byte),
    .data_valid(data_valid), .data_byte(data_byte), .commit(commit)
  );
endmodule

// File: rtl/i2c_wr_checker.sv
module i2c_wr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       addr_load,
  input logic       data_valid,
  input logic       data_ready,
  input logic [7:0] data_byte,
  input logic       commit
);
  a_r2_ack_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  a_r5_load_single: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |=> !addr_load);

  a_r6_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !data_ready) |=> (data_valid && $stable(data_byte)));

  a_r8_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  a_r8_commit_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !data_valid);
endmodule

bind i2c_eeprom_wr_target i2c_wr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .addr_load(addr_load), .data_valid(data_valid), .data_ready(data_ready),
  .data_byte(data_byte), .commit(commit)
);

// File: tb/tb_i2c_eeprom_wr_target.sv
module tb_i2c_eeprom_wr_target;
  localparam int Q = 10;
  localparam logic [2:0] CS = 3'b101;

  logic clk = 0, rst_n = 0;
  logic scl = 1, sda_m = 1;
  logic mem_busy = 0, data_ready = 1;
  logic oe0, oe1, sda_bus;
  logic addr_load, data_valid, commit;
  logic [7:0] addr_byte, data_byte;
  logic al1, dv1, cm1;
  logic [7:0] ab1, db1;

  int total = 0, bad = 0;
  int n_load = 0, n_data = 0, n_commit = 0;
  logic [7:0] last_addr, last_data;
  bit ack_any, done = 0;

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~oe0 & ~oe1;

  i2c_eeprom_wr_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .chip_sel(CS),
    .mem_busy(mem_busy), .sda_oe(oe0), .addr_load(addr_load),
    .addr_byte(addr_byte), .data_valid(data_valid), .data_ready(data_ready),
    .data_byte(data_byte), .commit(commit)
  );

  i2c_eeprom_wr_target #(.IGNORE_CS(1'b1)) dut_anycs (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .chip_sel(3'b000),
    .mem_busy(mem_busy), .sda_oe(oe1), .addr_load(al1), .addr_byte(ab1),
    .data_valid(dv1), .data_ready(1'b1), .data_byte(db1), .commit(cm1)
  );

  always @(negedge clk) begin
    if (addr_load) begin n_load++; last_addr = addr_byte; end
    if (data_valid && data_ready) begin n_data++; last_data = data_byte; end
    if (commit) n_commit++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; wq(Q); scl = 1; wq(Q); sda_m = 0; wq(Q); scl = 0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(Q); scl = 1; wq(Q); sda_m = 1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack0);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl = 1; wq(2*Q); scl = 0; wq(Q);
    end
    sda_m = 1; wq(Q); scl = 1; wq(Q);
    ack0 = oe0; ack_any = oe1;
    wq(Q); scl = 0; wq(Q);
  endtask

  task automatic t_byte_write();
    bit a; int l0 = n_load, d0 = n_data, c0 = n_commit;
    bus_start();
    send_byte({4'b1010, CS, 1'b0}, a); chk(a, "R2 select ack", a, 1);
    send_byte(8'h3C, a);               chk(a, "R5 address ack", a, 1);
    chk(n_load == l0 + 1 && last_addr == 8'h3C, "R5 addr_load value", last_addr, 8'h3C);
    send_byte(8'h96, a);               chk(a, "R6 data ack", a, 1);
    chk(n_data == d0 + 1 && last_data == 8'h96, "R6 data value", last_data, 8'h96);
    bus_stop(); wq(Q);
    chk(n_commit == c0 + 1, "R8 commit after stop", n_commit - c0, 1);
  endtask

  task automatic t_page();
    bit a; int d0 = n_data, c0 = n_commit;
    bus_start();
    send_byte({4'b1010, CS, 1'b0}, a);
    send_byte(8'h10, a);
    for (int k = 0; k < 3; k++) begin
      send_byte(8'hA0 + 8'(k), a);
      chk(a, "R6 page data ack", a, 1);
      chk(last_data == 8'hA0 + 8'(k), "R6 page data value", last_data, 8'hA0 + k);
    end
    chk(n_data == d0 + 3, "R6 page data count", n_data - d0, 3);
    bus_stop(); wq(3*Q);
    chk(n_commit == c0 + 1, "R8 single commit", n_commit - c0, 1);
  endtask

  task automatic t_wrong_sel();
    bit a; int l0 = n_load;
    bus_start();
    send_byte(8'h5A, a); chk(!a, "R3 wrong code nack", a, 0);
    send_byte(8'h22, a); chk(!a, "R3 ignored byte nack", a, 0);
    chk(n_load == l0, "R3 no addr_load", n_load - l0, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1010, 3'b010, 1'b0}, a);
    chk(!a, "R3 wrong chip select nack", a, 0);
    chk(ack_any, "R4 any chip select ack", ack_any, 1);
    send_byte(8'h44, a);
    chk(n_load == l0, "R3 no load after cs miss", n_load - l0, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1010, CS, 1'b0}, a); chk(a, "R3 next start accepted", a, 1);
    bus_stop();
  endtask

  task automatic t_busy();
    bit a; int l0 = n_load;
    mem_busy = 1;
    bus_start();
    send_byte({4'b1010, CS, 1'b0}, a); chk(!a, "R10 busy nack", a, 0);
    send_byte(8'h05, a);
    chk(n_load == l0, "R10 no load while busy", n_load - l0, 0);
    bus_stop();
    mem_busy = 0;
  endtask

  task automatic t_nodata();
    bit a; int c0 = n_commit;
    bus_start();
    send_byte({4'b1010, CS, 1'b0}, a);
    send_byte(8'h7F, a);
    bus_stop(); wq(3*Q);
    chk(n_commit == c0, "R9 no commit without data", n_commit - c0, 0);
  endtask

  task automatic t_restart();
    bit a; int c0 = n_commit;
    bus_start();
    send_byte({4'b1010, CS, 1'b0}, a);
    send_byte(8'h01, a);
    send_byte(8'hEE, a);
    bus_start();
    send_byte({4'b1010, CS, 1'b0}, a); chk(a, "R11 select after restart", a, 1);
    bus_stop(); wq(3*Q);
    chk(n_commit == c0, "R11 no commit after restart", n_commit - c0, 0);
  endtask

  task automatic t_read();
    bit a;
    bus_start();
    send_byte({4'b1010, CS, 1'b1}, a); chk(!a, "R12 read nack", a, 0);
    bus_stop();
  endtask

  task automatic t_backpressure();
    bit a; int d0 = n_data, c0 = n_commit;
    data_ready = 0;
    bus_start();
    send_byte({4'b1010, CS, 1'b0}, a);
    send_byte(8'h20, a);
    send_byte(8'h11, a); chk(a, "R7 first byte ack", a, 1);
    send_byte(8'h22, a); chk(!a, "R7 full slot nack", a, 0);
    chk(data_valid && data_byte == 8'h11, "R7 slot keeps byte", data_byte, 8'h11);
    bus_stop(); wq(3*Q);
    chk(n_commit == c0, "R8 commit waits for drain", n_commit - c0, 0);
    data_ready = 1; wq(3);
    chk(n_data == d0 + 1 && last_data == 8'h11, "R7 drained byte", last_data, 8'h11);
    wq(3);
    chk(n_commit == c0 + 1, "R8 commit after drain", n_commit - c0, 1);
  endtask

  initial begin
    wq(5);
    chk(!oe0 && !data_valid && !addr_load && !commit, "R1 reset outputs",
        {oe0, data_valid, addr_load, commit}, 0);
    rst_n = 1; wq(5);
    chk(!oe0 && !data_valid, "R1 idle after reset", {oe0, data_valid}, 0);
    t_byte_write();
    t_page();
    t_wrong_sel();
    t_busy();
    t_nodata();
    t_restart();
    t_read();
    t_backpressure();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule